// File: doc/BRIEF.md
# Scalar Load Address Generator

This block forms the byte address for a scalar memory load or store. A request gives a mode bit, a 128-bit word, a 32-bit unsigned offset and a valid strobe. One clock later the block returns a 64-bit address that always has its two low bits cleared. It also returns a flag that shows whether the offset was clamped.

The block has two modes. In plain mode, the low 64 bits of the input word are a base address taken from a register pair. The block adds the offset to this base. In buffer mode, the input word is a buffer resource descriptor, which holds a base, an element stride and a record count. The block first limits the offset to the extent of the buffer. It then adds the limited offset to the descriptor base. When the stride is zero, the extent is the record count. When the stride is nonzero, the extent is the product of the stride and the record count, computed at full width.

The block accepts one request every cycle, with no stalls. Issuing the memory request and returning data are handled by other logic.

Top module: `scalar_addr_gen`

## Requirements
- R1: In plain mode (`bufMode`=0) the address is (`baseOrDesc[63:0]` + zero-extended `offset`) modulo 2^64, with bits 1:0 forced to zero.
- R2: In buffer mode the descriptor fields sit at fixed positions: base in bits 47:0, stride in bits 61:48, record count in bits 95:64. Bits 63:62 and 127:96 have no effect on the address or the flag.
- R3: In buffer mode with a zero stride, an offset greater than or equal to the record count is replaced by the record count. This includes a record count of zero with an offset of zero.
- R4: In buffer mode with a nonzero stride, an offset strictly greater than stride × record count is replaced by that product. An offset equal to the product is kept. The product is exact over 46 bits and never wraps.
- R5: In buffer mode the address is (zero-extended descriptor base + limited offset) with bits 1:0 forced to zero. A carry above bit 47 is kept.
- R6: `clampedOut` is 1 in the cycle that carries a buffer-mode result whose offset was replaced. It is 0 in every other cycle, including all plain-mode results.
- R7: `outValid` is 1 exactly in the cycle after each cycle in which `inValid` is 1. Back-to-back requests produce back-to-back results.
- R8: While `outValid` is 0, `addrOut` keeps the last result.
- R9: After reset, `outValid`, `clampedOut` and `addrOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request strobe; the other inputs are sampled on this cycle |
| bufMode | input | 1 | 0: base pair plus offset; 1: buffer descriptor with clamping |
| baseOrDesc | input | 128 | Base pair in bits 63:0, or a full buffer descriptor |
| offset | input | 32 | Unsigned byte offset |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| addrOut | output | 64 | Dword-aligned byte address |
| clampedOut | output | 1 | The offset of this result was replaced by the buffer extent |

## Verification
The address and flag registers load only on a request. A stuck or wrongly enabled register therefore shows up in the first idle cycle, as an address that moves or a flag that stays high. A wrong compare in the clamp shows up only at the exact boundary offsets: equal to the extent, one above it, and a zero record count. The bench places requests on each of these boundaries for both stride cases. It also sends a stride and record count large enough that a product truncated below 46 bits would give the wrong address in the very next result.

// File: rtl/sag_pkg.sv
`timescale 1ns/1ps
package sag_pkg;
  // Descriptor geometry; the field positions are decoded by the producer
  parameter int DESC_W     = 128;
  parameter int DBASE_W    = 48;
  parameter int STRIDE_W   = 14;
  parameter int NREC_W     = 32;
  parameter int DBASE_LSB  = 0;
  parameter int STRIDE_LSB = 48;
  parameter int NREC_LSB   = 64;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;     // capture a new result
    logic clearFlag;  // drop the clamp flag after its cycle
  } sag_strobe_t;
endpackage

// File: rtl/sag_extent_clamp.sv
`timescale 1ns/1ps
module sag_extent_clamp #(
  parameter int STRIDE_W = 14,
  parameter int NREC_W   = 32,
  parameter int OFF_W    = 32,
  localparam int EXT_W   = STRIDE_W + NREC_W
) (
  input  logic [STRIDE_W-1:0] stride,
  input  logic [NREC_W-1:0]   numRec,
  input  logic [OFF_W-1:0]    offset,
  output logic [EXT_W-1:0]    limOffset,
  output logic                hit
);
  logic [EXT_W-1:0] extent;
  logic [EXT_W-1:0] offWide;
  logic [EXT_W-1:0] recWide;
  logic             strideZero;
  logic             hitFlat;
  logic             hitStrided;

  always_comb begin
    // full-precision product, no wrap possible in EXT_W bits
    extent     = EXT_W'(stride) * EXT_W'(numRec);
    offWide    = EXT_W'(offset);
    recWide    = EXT_W'(numRec);
    strideZero = (stride == '0);
    hitFlat    = (offWide >= recWide);
    hitStrided = (offWide > extent);
    hit        = strideZero ? hitFlat : hitStrided;
    if (hit) limOffset = strideZero ? recWide : extent;
    else     limOffset = offWide;
  end
endmodule

// File: rtl/sag_control.sv
`timescale 1ns/1ps
module sag_control
  import sag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output sag_strobe_t strobes,
  output logic        outValid
);
  always_comb begin
    strobes.loadEn    = inValid;
    strobes.clearFlag = ~inValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end
endmodule

// File: rtl/sag_datapath.sv
`timescale 1ns/1ps
module sag_datapath
  import sag_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int OFF_W      = 32,
  parameter int ALIGN_BITS = 2,
  localparam int EXT_W     = STRIDE_W + NREC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sag_strobe_t       strobes,
  input  logic              bufMode,
  input  logic [DESC_W-1:0] baseOrDesc,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] addrOut,
  output logic              clampedOut
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK =
    ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

  logic [DBASE_W-1:0]  descBase;
  logic [STRIDE_W-1:0] descStride;
  logic [NREC_W-1:0]   descRec;
  logic [EXT_W-1:0]    limOffset;
  logic                clampHit;
  logic [ADDR_W-1:0]   plainSum;
  logic [ADDR_W-1:0]   bufSum;
  logic [ADDR_W-1:0]   nextAddr;
  logic                nextFlag;

  always_comb begin
    descBase   = baseOrDesc[DBASE_LSB  +: DBASE_W];
    descStride = baseOrDesc[STRIDE_LSB +: STRIDE_W];
    descRec    = baseOrDesc[NREC_LSB   +: NREC_W];
  end

  sag_extent_clamp #(
    .STRIDE_W(STRIDE_W),
    .NREC_W  (NREC_W),
    .OFF_W   (OFF_W)
  ) clamp_i (
    .stride   (descStride),
    .numRec   (descRec),
    .offset   (offset),
    .limOffset(limOffset),
    .hit      (clampHit)
  );

  always_comb begin
    plainSum = baseOrDesc[ADDR_W-1:0] + ADDR_W'(offset);
    bufSum   = ADDR_W'(descBase) + ADDR_W'(limOffset);
    nextAddr = (bufMode ? bufSum : plainSum) & ALIGN_MASK;
    nextFlag = bufMode & clampHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrOut    <= '0;
      clampedOut <= 1'b0;
    end else if (strobes.loadEn) begin
      addrOut    <= nextAddr;
      clampedOut <= nextFlag;
    end else if (strobes.clearFlag) begin
      clampedOut <= 1'b0;
    end
  end
endmodule

// File: rtl/scalar_addr_gen.sv
`timescale 1ns/1ps
module scalar_addr_gen
  import sag_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int OFF_W      = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              bufMode,
  input  logic [DESC_W-1:0] baseOrDesc,
  input  logic [OFF_W-1:0]  offset,
  output logic              outValid,
  output logic [ADDR_W-1:0] addrOut,
  output logic              clampedOut
);
  sag_strobe_t strobes;

  sag_control ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  sag_datapath #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .ALIGN_BITS(ALIGN_BITS)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .bufMode   (bufMode),
    .baseOrDesc(baseOrDesc),
    .offset    (offset),
    .addrOut   (addrOut),
    .clampedOut(clampedOut)
  );
endmodule

// File: rtl/sag_checker.sv
`timescale 1ns/1ps
module sag_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         inValid,
  input logic         bufMode,
  input logic [127:0] baseOrDesc,
  input logic [31:0]  offset,
  input logic         outValid,
  input logic [63:0]  addrOut,
  input logic         clampedOut
);
  logic [13:0] chkStride;
  logic [31:0] chkRec;
  assign chkStride = baseOrDesc[61:48];
  assign chkRec    = baseOrDesc[95:64];

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  // R6
  flag_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clampedOut |-> outValid);
  // R6
  plain_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !bufMode) |=> !clampedOut);
  // R1
  plain_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !bufMode) |=>
      addrOut == (($past(baseOrDesc[63:0]) + {32'h0, $past(offset)}) & ~64'h3));
  // R5
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> addrOut[1:0] == 2'b00);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(addrOut));
  // R3
  flat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && bufMode && chkStride == 14'h0 && offset >= chkRec) |=> clampedOut);
endmodule

bind scalar_addr_gen sag_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .inValid   (inValid),
  .bufMode   (bufMode),
  .baseOrDesc(baseOrDesc),
  .offset    (offset),
  .outValid  (outValid),
  .addrOut   (addrOut),
  .clampedOut(clampedOut)
);

// File: tb/scalar_addr_gen_tb_top.sv
`timescale 1ns/1ps
module scalar_addr_gen_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         bufMode = 1'b0;
  logic [127:0] baseOrDesc = '0;
  logic [31:0]  offset = '0;
  logic         outValid;
  logic [63:0]  addrOut;
  logic         clampedOut;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;
  logic [63:0] lastAddr = '0;

  typedef struct {
    logic [63:0] a;
    logic        c;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  scalar_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .bufMode(bufMode),
    .baseOrDesc(baseOrDesc), .offset(offset), .outValid(outValid),
    .addrOut(addrOut), .clampedOut(clampedOut)
  );

  function automatic logic [127:0] mkDesc(input logic [47:0] b, input logic [13:0] s,
                                          input logic [31:0] n, input bit junk);
    logic [127:0] d;
    d = '0;
    d[47:0]  = b;
    d[61:48] = s;
    d[95:64] = n;
    if (junk) begin
      d[63:62]  = 2'b11;
      d[127:96] = 32'hDEAD_BEEF;
    end
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic issue(input logic m, input logic [127:0] d, input logic [31:0] o,
                       input string tag);
    exp_t e;
    logic [63:0] lim;
    logic [63:0] ext;
    logic [63:0] b;
    logic [63:0] st;
    logic [63:0] nr;
    @(negedge clk);
    e.c = 1'b0;
    if (!m) begin
      e.a = (d[63:0] + {32'h0, o}) & ~64'h3;
    end else begin
      b   = {16'h0, d[47:0]};
      st  = {50'h0, d[61:48]};
      nr  = {32'h0, d[95:64]};
      lim = {32'h0, o};
      if (st == 0) begin
        if (lim >= nr) begin lim = nr; e.c = 1'b1; end
      end else begin
        ext = st * nr;
        if (lim > ext) begin lim = ext; e.c = 1'b1; end
      end
      e.a = (b + lim) & ~64'h3;
    end
    e.tag = tag;
    q.push_back(e);
    inValid = 1'b1; bufMode = m; baseOrDesc = d; offset = o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      baseOrDesc = {4{32'h5A5A_A5A5}};
      offset = 32'hFFFF_FFFF;
      bufMode = ~bufMode;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (started) begin
      if (outValid) begin
        if (q.size() == 0) begin
          check(1'b0, "R7 unexpected result", addrOut, 64'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(addrOut == e.a, e.tag, addrOut, e.a);
          check(clampedOut == e.c, {e.tag, " R6 flag"}, {63'h0, clampedOut}, {63'h0, e.c});
          lastAddr = addrOut;
        end
      end else begin
        check(addrOut == lastAddr, "R8 hold", addrOut, lastAddr);
        check(clampedOut == 1'b0, "R6 idle flag", {63'h0, clampedOut}, 64'h0);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(outValid == 1'b0, "R9 outValid", {63'h0, outValid}, 64'h0);
    check(addrOut == 64'h0, "R9 addrOut", addrOut, 64'h0);
    check(clampedOut == 1'b0, "R9 clampedOut", {63'h0, clampedOut}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    started = 1;

    // R1 plain mode
    issue(1'b0, {64'h0, 64'h0000_1234_5678_9AB0}, 32'h10, "R1 aligned");
    issue(1'b0, {64'hFFFF, 64'h0000_0000_0000_1003}, 32'h2, "R1 unaligned");
    issue(1'b0, {64'h0, 64'hFFFF_FFFF_FFFF_FFF0}, 32'h20, "R1 wrap");
    issue(1'b0, {64'h0, 64'h0000_0000_0000_0100}, 32'hFFFF_FFFF, "R1 big offset no flag R6");
    idle(2);
    // R3 zero stride
    issue(1'b1, mkDesc(48'h1000, 14'h0, 32'd100, 0), 32'd50, "R3 below");
    issue(1'b1, mkDesc(48'h1000, 14'h0, 32'd100, 0), 32'd100, "R3 equal");
    issue(1'b1, mkDesc(48'h1000, 14'h0, 32'd100, 0), 32'd5000, "R3 above");
    issue(1'b1, mkDesc(48'h2000, 14'h0, 32'd0, 0), 32'd0, "R3 zero count");
    idle(1);
    // R4 nonzero stride
    issue(1'b1, mkDesc(48'h4000, 14'd16, 32'd10, 0), 32'd160, "R4 equal kept");
    issue(1'b1, mkDesc(48'h4000, 14'd16, 32'd10, 0), 32'd161, "R4 above");
    issue(1'b1, mkDesc(48'h4000, 14'h3FFF, 32'hFFFF_FFFF, 0), 32'hFFFF_FFFF, "R4 wide product");
    issue(1'b1, mkDesc(48'h4000, 14'h3FFF, 32'd1, 0), 32'h0001_0000, "R4 small extent");
    idle(3);
    // R2 junk bits ignored
    issue(1'b1, mkDesc(48'h1000, 14'h0, 32'd100, 1), 32'd50, "R2 junk below");
    issue(1'b1, mkDesc(48'h4000, 14'd16, 32'd10, 1), 32'd161, "R2 junk above");
    // R5 carry above 48 bits
    issue(1'b1, mkDesc(48'hFFFF_FFFF_FFFF, 14'd4, 32'd8, 0), 32'd7, "R5 carry");
    issue(1'b1, mkDesc(48'h0000_0000_0003, 14'd1, 32'd100, 0), 32'd1, "R5 align");
    idle(4);
    if (q.size() != 0) check(1'b0, "R7 missing results", 64'(q.size()), 64'h0);
    else check(1'b1, "R7 all results", 64'h0, 64'h0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule